// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt events for a small 8-bit processor and offers the processor one interrupt at a time, together with the 16-bit address of its vector pair. The sources fall into four groups. Nine on-chip events (serial, timer and converter completions) arrive as one-cycle pulses. Four external pins pass through a synchronizer and an edge detector whose polarity software selects. One key wake-up source fires when the AND of the port pins that are in input mode falls from 1 to 0. The last two are a boot interrupt, which is pending out of reset, and a break request that cannot be masked.

Each maskable source has a request bit and an enable bit. These sit in two 8-bit request registers and two 8-bit enable registers, which software reads and writes over a small register bus. A global disable flag is held in the block. The processor loads it through a flag write port, and the block raises it by itself whenever an interrupt is accepted. The processor accepts the offered interrupt by pulsing an acknowledge. That clears the winning request bit and sets the flag, so nested interrupts are held off until software clears the flag again.

Top module: `vic_top`

## Requirements
- R1: After reset, every register reads 0, flag_q is 1, and the boot interrupt is pending at slot 0 with vector FFFC until it is acknowledged.
- R2: A maskable source is offered only when its request bit is 1, its enable bit is 1 and flag_q is 0.
- R3: When more than one maskable source is active, the lowest request bit index wins. The boot interrupt outranks all of them, and break ranks below all of them.
- R4: irq_slot is 0 for boot, i+1 for request bit i, and 16 for break. irq_vec equals FFFC minus twice the slot, so break gives FFDC.
- R5: An acknowledge while irq_pending is high clears the winning request bit and sets flag_q on the same clock edge.
- R6: A register write clears each request bit written as 0 and leaves each bit written as 1 unchanged. A hardware set in the same cycle as a software clear wins.
- R7: Register map. Address 0 holds request bits 7:0 and address 1 holds request bits 13:8. Addresses 2 and 3 hold the enable bits in the same layout. Address 4 is the configuration register: bits 0 to 3 select the active edge of pin_x0, pin_x1, pin_c0 and pin_c1 (0 = falling, 1 = rising), and bit 7 = 1 removes key pin 0 from the wake-up AND. All other bits, and all other addresses, read 0.
- R8: An external pin sets its request bit (pin_x0: bit 2, pin_x1: bit 3, pin_c0: bit 5, pin_c1: bit 6) only on its selected edge. The bit becomes visible on the third rising clock edge after the pin changes. The opposite edge sets nothing.
- R9: If a polarity bit is changed while the pin sits at the level that the new edge ends on, the pin's request bit is set.
- R10: Request bit 4 is set when the AND of the key pins falls from 1 to 0. Only pins with key_out_en = 0 take part, and pin 0 also drops out when configuration bit 7 is 1.
- R11: While brk_req is high, an interrupt is pending at slot 16 regardless of flag_q and the enables, unless a higher-ranked source is offered.
- R12: chip_evt bits 0 to 8 set request bits 0, 1, 7, 8, 9, 10, 11, 12 and 13 on the next clock edge.
- R13: flag_wr loads flag_wdata into flag_q. When an acknowledge is accepted in the same cycle, flag_q becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_evt | input | 9 | One-cycle on-chip event pulses |
| pin_x0 | input | 1 | External pin, request bit 2 |
| pin_x1 | input | 1 | External pin, request bit 3 |
| pin_c0 | input | 1 | External pin, request bit 5 |
| pin_c1 | input | 1 | External pin, request bit 6 |
| key_pin | input | KEY_W | Key port pin levels |
| key_out_en | input | KEY_W | 1 = pin is in output mode and takes no part in the wake-up AND |
| brk_req | input | 1 | Break request from the processor (non-maskable) |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| flag_wr | input | 1 | Global disable flag write strobe |
| flag_wdata | input | 1 | Global disable flag write value |
| flag_q | output | 1 | Global disable flag |
| irq_ack | input | 1 | Processor accepts the offered interrupt |
| irq_pending | output | 1 | An interrupt is being offered |
| irq_vec | output | 16 | Vector pair address of the offered interrupt |
| irq_slot | output | 5 | Priority slot of the offered interrupt |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, an 8-pin key port, and the vector table topped at FFFC. With two stages, the three-edge latency from an external pin to its request bit can be checked cycle-exactly. The 8-pin port lets a mix of input-mode and output-mode pins show which pins the wake-up AND ignores. With the FFFC top, every slot's vector, including FFDC for break, can be compared against a value the bench computes on its own.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NREQ   = 14;
  localparam int SLOT_W = 5;
  localparam logic [SLOT_W-1:0] SLOT_BOOT = 5'd0;
  localparam logic [SLOT_W-1:0] SLOT_BRK  = 5'd16;

  // request bit positions (their order is the priority order)
  localparam int RB_RX1 = 0;
  localparam int RB_TX1 = 1;
  localparam int RB_X0  = 2;
  localparam int RB_X1  = 3;
  localparam int RB_KEY = 4;
  localparam int RB_C0  = 5;
  localparam int RB_C1  = 6;
  localparam int RB_TMX = 7;
  localparam int RB_TMY = 8;
  localparam int RB_TMZ = 9;
  localparam int RB_TMA = 10;
  localparam int RB_SR2 = 11;
  localparam int RB_ADC = 12;
  localparam int RB_TM1 = 13;

  localparam logic [2:0] A_REQ_LO = 3'd0;
  localparam logic [2:0] A_REQ_HI = 3'd1;
  localparam logic [2:0] A_EN_LO  = 3'd2;
  localparam logic [2:0] A_EN_HI  = 3'd3;
  localparam logic [2:0] A_CFG    = 3'd4;

  localparam logic [7:0] CFG_MASK = 8'h8F;
  localparam int CFG_KEY_EXCL = 7;

  // vector pair address: two bytes per slot, counting down from the top
  function automatic logic [15:0] slot_vector(input logic [15:0] top,
                                              input logic [SLOT_W-1:0] slot);
    return top - {10'd0, slot, 1'b0};
  endfunction

  // slot of the lowest active request bit, 0 if none
  function automatic logic [SLOT_W-1:0] first_req(input logic [NREQ-1:0] act);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (act[i]) r = SLOT_W'(i + 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/vic_edge_det.sv
module vic_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic active_lvl;
  logic active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= pin;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  // level that the selected edge ends on; a rise of it is an event
  assign active_lvl = rise_sel ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b1;
    else        active_q <= active_lvl;
  end

  assign hit = active_lvl & ~active_q;
endmodule

// File: rtl/vic_key_wake.sv
module vic_key_wake #(
  parameter int KEY_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] key_pin,
  input  logic [KEY_W-1:0] key_out_en,
  input  logic             excl_pin0,
  output logic             hit
);
  logic [KEY_W-1:0] sync_q [SYNC_STAGES];
  logic [KEY_W-1:0] ignore_mask;
  logic             and_lvl;
  logic             and_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '1;
    end else begin
      sync_q[0] <= key_pin;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign ignore_mask = key_out_en | {{(KEY_W-1){1'b0}}, excl_pin0};
  assign and_lvl     = &(sync_q[SYNC_STAGES-1] | ignore_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) and_q <= 1'b1;
    else        and_q <= and_lvl;
  end

  assign hit = and_q & ~and_lvl;
endmodule

// File: rtl/vic_reqbank.sv
module vic_reqbank
  import vic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] hw_set,
  input  logic [NREQ-1:0] acc_clr,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [NREQ-1:0] sw_clr,
  output logic [NREQ-1:0] req_q,
  output logic [NREQ-1:0] en_q,
  output logic [7:0]      cfg_q
);
  localparam int HI_W = NREQ - 8;

  logic [15:0] clr16;

  always_comb begin
    clr16 = '0;
    if (reg_wr && reg_addr == A_REQ_LO) clr16[7:0]  = ~reg_wdata;
    if (reg_wr && reg_addr == A_REQ_HI) clr16[15:8] = ~reg_wdata;
  end
  assign sw_clr = clr16[NREQ-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= (req_q & ~sw_clr & ~acc_clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_EN_LO) en_q[7:0]    <= reg_wdata;
      if (reg_addr == A_EN_HI) en_q[NREQ-1:8] <= reg_wdata[HI_W-1:0];
      if (reg_addr == A_CFG)   cfg_q        <= reg_wdata & CFG_MASK;
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
(
  input  logic              boot_pend,
  input  logic [NREQ-1:0]   act,
  input  logic              brk_req,
  output logic              pend,
  output logic [SLOT_W-1:0] slot
);
  always_comb begin
    if (boot_pend)     slot = SLOT_BOOT;
    else if (|act)     slot = first_req(act);
    else if (brk_req)  slot = SLOT_BRK;
    else               slot = SLOT_BOOT;
  end
  assign pend = boot_pend | (|act) | brk_req;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          KEY_W       = 8,
  parameter logic [15:0] VEC_TOP     = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [8:0]       chip_evt,
  input  logic             pin_x0,
  input  logic             pin_x1,
  input  logic             pin_c0,
  input  logic             pin_c1,
  input  logic [KEY_W-1:0] key_pin,
  input  logic [KEY_W-1:0] key_out_en,
  input  logic             brk_req,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             flag_q,
  input  logic             irq_ack,
  output logic             irq_pending,
  output logic [15:0]      irq_vec,
  output logic [4:0]       irq_slot
);
  localparam int NPIN = 4;

  logic [NPIN-1:0]   ext_pins;
  logic [NPIN-1:0]   pin_hit;
  logic              key_hit;
  logic [NREQ-1:0]   hw_set;
  logic [NREQ-1:0]   sw_clr;
  logic [NREQ-1:0]   acc_clr;
  logic [NREQ-1:0]   req_q;
  logic [NREQ-1:0]   en_q;
  logic [NREQ-1:0]   act;
  logic [7:0]        cfg_q;
  logic              boot_pend;
  logic              acc_fire;
  logic [SLOT_W-1:0] win_slot;
  logic [15:0]       req16;
  logic [15:0]       en16;

  assign ext_pins = {pin_c1, pin_c0, pin_x1, pin_x0};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    vic_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pins[g]),
      .rise_sel (cfg_q[g]),
      .hit      (pin_hit[g])
    );
  end

  vic_key_wake #(.KEY_W(KEY_W), .SYNC_STAGES(SYNC_STAGES)) u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_pin    (key_pin),
    .key_out_en (key_out_en),
    .excl_pin0  (cfg_q[CFG_KEY_EXCL]),
    .hit        (key_hit)
  );

  always_comb begin
    hw_set         = '0;
    hw_set[RB_RX1] = chip_evt[0];
    hw_set[RB_TX1] = chip_evt[1];
    hw_set[RB_X0]  = pin_hit[0];
    hw_set[RB_X1]  = pin_hit[1];
    hw_set[RB_KEY] = key_hit;
    hw_set[RB_C0]  = pin_hit[2];
    hw_set[RB_C1]  = pin_hit[3];
    hw_set[RB_TMX] = chip_evt[2];
    hw_set[RB_TMY] = chip_evt[3];
    hw_set[RB_TMZ] = chip_evt[4];
    hw_set[RB_TMA] = chip_evt[5];
    hw_set[RB_SR2] = chip_evt[6];
    hw_set[RB_ADC] = chip_evt[7];
    hw_set[RB_TM1] = chip_evt[8];
  end

  vic_reqbank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_set    (hw_set),
    .acc_clr   (acc_clr),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sw_clr    (sw_clr),
    .req_q     (req_q),
    .en_q      (en_q),
    .cfg_q     (cfg_q)
  );

  assign act = req_q & en_q & {NREQ{~flag_q}};

  vic_prio u_prio (
    .boot_pend (boot_pend),
    .act       (act),
    .brk_req   (brk_req),
    .pend      (irq_pending),
    .slot      (win_slot)
  );

  assign acc_fire = irq_ack & irq_pending;

  for (genvar i = 0; i < NREQ; i++) begin : g_clr
    assign acc_clr[i] = acc_fire && (win_slot == SLOT_W'(i + 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b1;
    else if (acc_fire) flag_q <= 1'b1;
    else if (flag_wr)  flag_q <= flag_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  boot_pend <= 1'b1;
    else if (acc_fire && win_slot == SLOT_BOOT)  boot_pend <= 1'b0;
  end

  assign irq_slot = win_slot;
  assign irq_vec  = slot_vector(VEC_TOP, win_slot);

  assign req16 = {{(16-NREQ){1'b0}}, req_q};
  assign en16  = {{(16-NREQ){1'b0}}, en_q};

  always_comb begin
    case (reg_addr)
      A_REQ_LO: reg_rdata = req16[7:0];
      A_REQ_HI: reg_rdata = req16[15:8];
      A_EN_LO:  reg_rdata = en16[7:0];
      A_EN_HI:  reg_rdata = en16[15:8];
      A_CFG:    reg_rdata = cfg_q;
      default:  reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flag_q,
  input logic        irq_pending,
  input logic [4:0]  irq_slot,
  input logic        brk_req,
  input logic        acc_fire,
  input logic [13:0] req_q,
  input logic [13:0] en_q,
  input logic [13:0] hw_set,
  input logic [13:0] acc_clr
);
  logic [3:0] ix;
  logic       maskable;
  assign ix       = 4'(irq_slot - 5'd1);
  assign maskable = irq_pending && irq_slot >= 5'd1 && irq_slot <= 5'd14;

  // R2
  maskable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maskable |-> (!flag_q && req_q[ix] && en_q[ix]));

  // R5
  accept_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> flag_q);

  // R5
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc_clr) |=> ((req_q & $past(acc_clr) & ~$past(hw_set)) == 14'd0));

  // R5
  accept_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_clr));

  // R6
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~$past(req_q) & ~$past(hw_set)) == 14'd0));

  // R11
  brk_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> irq_pending);
endmodule

bind vic_top vic_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flag_q      (flag_q),
  .irq_pending (irq_pending),
  .irq_slot    (irq_slot),
  .brk_req     (brk_req),
  .acc_fire    (acc_fire),
  .req_q       (req_q),
  .en_q        (en_q),
  .hw_set      (hw_set),
  .acc_clr     (acc_clr)
);

// File: tb/sim_vic_top.sv
`timescale 1ns/100ps
module sim_vic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  chip_evt = '0;
  logic        pin_x0 = 1'b1, pin_x1 = 1'b1, pin_c0 = 1'b1, pin_c1 = 1'b1;
  logic [7:0]  key_pin = 8'hFF;
  logic [7:0]  key_out_en = 8'hF0;
  logic        brk_req = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        flag_wr = 1'b0, flag_wdata = 1'b0;
  logic        flag_q;
  logic        irq_ack = 1'b0;
  logic        irq_pending;
  logic [15:0] irq_vec;
  logic [4:0]  irq_slot;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vic_top u0 (
    .clk(clk), .rst_n(rst_n), .chip_evt(chip_evt),
    .pin_x0(pin_x0), .pin_x1(pin_x1), .pin_c0(pin_c0), .pin_c1(pin_c1),
    .key_pin(key_pin), .key_out_en(key_out_en), .brk_req(brk_req),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flag_q(flag_q),
    .irq_ack(irq_ack), .irq_pending(irq_pending), .irq_vec(irq_vec), .irq_slot(irq_slot)
  );

  typedef struct packed {
    logic [8:0]  evt;
    logic [15:0] en;
    logic        pend;
    logic [4:0]  slot;
  } row_t;

  // R3 R4 R12: event pattern, enables, expected winner
  localparam row_t TBL [0:6] = '{
    '{9'h001, 16'hFFFF, 1'b1, 5'd1},
    '{9'h104, 16'hFFFF, 1'b1, 5'd8},
    '{9'h100, 16'hFFFF, 1'b1, 5'd14},
    '{9'h048, 16'hFEFF, 1'b1, 5'd12},
    '{9'h080, 16'h0000, 1'b0, 5'd0},
    '{9'h1FF, 16'hFFFF, 1'b1, 5'd1},
    '{9'h022, 16'h0400, 1'b1, 5'd11}
  };

  function automatic logic [15:0] exp_vec(input logic [4:0] s);
    return 16'hFFFC - 16'(s) * 16'd2;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_flag(input logic v);
    @(negedge clk);
    flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  task automatic pulse(input logic [8:0] e);
    @(negedge clk);
    chip_evt = e;
    @(negedge clk);
    chip_evt = '0;
    #1;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    #1;
  endtask

  task automatic clear_reqs();
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    #1;
    // R1 reset state
    chk("R1 pending", irq_pending, 1);
    chk("R1 vec", irq_vec, 16'hFFFC);
    chk("R1 slot", irq_slot, 0);
    chk("R1 flag", flag_q, 1);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reg", d, 0);
    end
    ack();
    chk("R1 boot accepted", irq_pending, 0);

    // R3 R4 R12 table
    for (int t = 0; t < 7; t++) begin
      wr(3'd2, TBL[t].en[7:0]);
      wr(3'd3, TBL[t].en[15:8]);
      set_flag(1'b0);
      pulse(TBL[t].evt);
      chk("R3 pending", irq_pending, TBL[t].pend);
      if (TBL[t].pend) begin
        chk("R3 slot", irq_slot, TBL[t].slot);
        chk("R4 vec", irq_vec, exp_vec(TBL[t].slot));
      end
      clear_reqs();
    end

    // R2 global flag masks
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    set_flag(1'b1);
    pulse(9'h004);
    chk("R2 masked", irq_pending, 0);
    set_flag(1'b0);
    #1;
    chk("R2 unmasked", irq_pending, 1);
    chk("R2 slot", irq_slot, 8);

    // R5 accept clears bit and sets flag
    ack();
    chk("R5 flag", flag_q, 1);
    rd(3'd0, d);
    chk("R5 cleared", d, 8'h00);

    // R6 write semantics
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    chk("R6 write1 no set", d, 8'h00);
    pulse(9'h003);
    wr(3'd0, 8'hFD);
    rd(3'd0, d);
    chk("R6 write0 clears", d, 8'h01);
    @(negedge clk);
    reg_addr = 3'd0; reg_wdata = 8'h00; reg_wr = 1'b1; chip_evt = 9'h002;
    @(negedge clk);
    reg_wr = 1'b0; chip_evt = '0;
    rd(3'd0, d);
    chk("R6 hw wins", d, 8'h02);
    clear_reqs();

    // R7 register map
    rd(3'd3, d);
    chk("R7 en hi", d, 8'h3F);
    wr(3'd4, 8'hFF);
    rd(3'd4, d);
    chk("R7 cfg", d, 8'h8F);
    wr(3'd4, 8'h00);
    rd(3'd5, d);
    chk("R7 unmapped", d, 8'h00);
    clear_reqs();

    // R8 falling edge on pin_x0, latency
    @(negedge clk);
    pin_x0 = 1'b0;
    tick(2);
    reg_addr = 3'd0; #1;
    chk("R8 not yet", reg_rdata, 8'h00);
    tick(1);
    #1;
    chk("R8 fall sets", reg_rdata, 8'h04);
    clear_reqs();
    @(negedge clk);
    pin_x0 = 1'b1;
    tick(4);
    rd(3'd0, d);
    chk("R8 rise ignored", d, 8'h00);

    // R9 polarity change with pin_x1 high
    wr(3'd4, 8'h02);
    tick(2);
    rd(3'd0, d);
    chk("R9 spurious", d, 8'h08);
    clear_reqs();

    // R10 key wake
    @(negedge clk); key_pin[6] = 1'b0;
    tick(4);
    rd(3'd0, d);
    chk("R10 output pin ignored", d, 8'h00);
    @(negedge clk); key_pin[6] = 1'b1; key_pin[2] = 1'b0;
    tick(4);
    rd(3'd0, d);
    chk("R10 input pin falls", d, 8'h10);
    @(negedge clk); key_pin[2] = 1'b1;
    clear_reqs();
    wr(3'd4, 8'h82);
    @(negedge clk); key_pin[0] = 1'b0;
    tick(4);
    rd(3'd0, d);
    chk("R10 pin0 excluded", d, 8'h00);
    @(negedge clk); key_pin[0] = 1'b1;
    tick(4);
    wr(3'd4, 8'h02);
    @(negedge clk); key_pin[0] = 1'b0;
    tick(4);
    rd(3'd0, d);
    chk("R10 pin0 included", d, 8'h10);
    @(negedge clk); key_pin[0] = 1'b1;
    tick(4);
    clear_reqs();

    // R11 break
    set_flag(1'b1);
    @(negedge clk); brk_req = 1'b1;
    #1;
    chk("R11 brk pending", irq_pending, 1);
    chk("R11 brk vec", irq_vec, 16'hFFDC);
    chk("R11 brk slot", irq_slot, 16);
    set_flag(1'b0);
    pulse(9'h100);
    chk("R11 maskable outranks brk", irq_slot, 14);
    ack();
    chk("R11 brk after accept", irq_slot, 16);

    // R13 flag write vs accept
    @(negedge clk);
    irq_ack = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0;
    @(negedge clk);
    irq_ack = 1'b0; flag_wr = 1'b0;
    #1;
    chk("R13 accept wins", flag_q, 1);
    @(negedge clk); brk_req = 1'b0;
    set_flag(1'b0);
    #1;
    chk("R13 flag write", flag_q, 0);
    chk("R11 brk released", irq_pending, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule